// File: doc/BRIEF.md
# MIDI Receive Timestamp Buffer

This block stamps incoming serial MIDI bytes with their arrival time and queues them for a host. A free-running enable at 1 MHz drives a 16-bit up-counter. The counter is preloaded so that it overflows roughly once per millisecond. Each overflow advances a 24-bit timestamp. A host command opens a timestamped read. That command clears the timer and the timestamp and starts the measurement.

When the first received byte of a command arrives, the block captures the timestamp. It writes the three timestamp bytes into the receive FIFO, least significant first, and then writes the data byte. Every later byte goes straight into the FIFO. The host pulls bytes out one at a time. Bytes that do not fit are dropped, and a sticky flag records the loss.

The UART receiver sits outside this block. It delivers bytes as single-cycle `rx_valid` strobes, at least five cycles apart.

Top module: `midi_ts_buf`

## Requirements
- R1: After reset, `out_valid`, `ts_active` and `ovf_flag` are all 0.
- R2: A `cmd_start` pulse does the following: it loads the timer with RELOAD, clears the timestamp to 0, empties the FIFO, clears `ovf_flag` and raises `ts_active`. A second start clears them all again. If `cmd_start` and `cmd_stop` arrive together, `cmd_start` wins.
- R3: While active, each `us_tick` advances the timer by one. A tick at 0xFFFF instead reloads RELOAD and increments the 24-bit timestamp, so one timestamp step spans 65536-RELOAD ticks (1001 at the default 0xFC17).
- R4: `ts_active` goes high the cycle after `cmd_start` and low the cycle after `cmd_stop`. Ticks advance the timer only while it is high.
- R5: The first byte after a start fixes the timestamp at the value held before that clock edge. In the next four cycles the FIFO receives that timestamp's bits 7:0, then bits 15:8, then bits 23:16, then the data byte. The timer keeps counting during these cycles.
- R6: Later bytes of the same command enter the FIFO directly, in arrival order, with no further timestamp.
- R7: Bytes arriving while `ts_active` is 0 are ignored and leave the FIFO unchanged.
- R8: `out_valid` is 1 whenever the FIFO holds data, and `out_data` shows the oldest byte. `host_rd` removes that byte. `host_rd` on an empty FIFO has no effect.
- R9: A write to a full FIFO is dropped. It sets `ovf_flag`, which stays 1 until the next `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | 1 MHz timer enable, one cycle wide |
| cmd_start | input | 1 | Begin a timestamped read |
| cmd_stop | input | 1 | End the timestamped read |
| rx_valid | input | 1 | Received MIDI byte strobe |
| rx_data | input | 8 | Received MIDI byte |
| host_rd | input | 1 | Host removes the head byte |
| out_valid | output | 1 | FIFO not empty |
| out_data | output | 8 | Head byte of the FIFO |
| ts_active | output | 1 | Timestamp mode flag |
| ovf_flag | output | 1 | Sticky dropped-byte flag |

## Verification
The bench builds the block with RELOAD = 0xFFF6 and a FIFO depth of 8. With that RELOAD, one timestamp step takes ten ticks, so many reload cycles fit into short runs. Ticks number in the thousands, so values of 256 and above exercise the middle timestamp byte. The small depth makes the full and drop path reachable with a single stamp and a few data bytes. Random tick counts and data bytes from a fixed seed check the stamp value and byte order across many commands.

// File: rtl/midi_ts_pkg.sv
package midi_ts_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_STAMP,
        ST_DATA,
        ST_RUN
    } seq_st_e;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } wr_req_t;

    // Pick byte lane k out of a wide word.
    function automatic byte_t byte_of(input logic [63:0] word, input logic [2:0] k);
        return word[{k, 3'b000} +: BYTE_W];
    endfunction

endpackage

// File: rtl/midi_ts_timer.sv
module midi_ts_timer #(
    parameter int              TIMER_W = 16,
    parameter logic [TIMER_W-1:0] RELOAD = 16'hFC17,
    parameter int              TS_W    = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            run,
    input  logic            tick,
    output logic [TS_W-1:0] ts_value
);
    logic [TIMER_W-1:0] timer_q;
    logic [TS_W-1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            timer_q <= RELOAD;
            cnt_q   <= '0;
        end else if (run && tick) begin
            if (timer_q == '1) begin
                timer_q <= RELOAD;
                cnt_q   <= cnt_q + 1'b1;
            end else begin
                timer_q <= timer_q + 1'b1;
            end
        end
    end

    assign ts_value = cnt_q;

    // R3: wrap reloads and steps the timestamp
    p_wrap_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !clr && timer_q == '1) |=>
            (timer_q == RELOAD && cnt_q == $past(cnt_q) + 1'b1));

    // R2: start clears the timestamp
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0 && timer_q == RELOAD));

    // R4: idle timer holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(timer_q));
endmodule

// File: rtl/midi_ts_fifo.sv
module midi_ts_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         rd,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         full
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = AW + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_wr, do_rd;

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign out_data  = mem[rp_q];
    assign do_wr     = wr && !full && !flush;
    assign do_rd     = rd && out_valid && !flush;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_rd) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    // R9: occupancy never exceeds depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    // R9: a write into a full FIFO changes nothing
    p_drop_full_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && full && !rd && !flush) |=> (cnt_q == $past(cnt_q)));

    // R8: read of empty FIFO has no effect
    p_empty_rd_r8: assert property (@(posedge clk) disable iff (rst)
        (rd && !out_valid && !wr && !flush) |=> !out_valid);
endmodule

// File: rtl/midi_ts_seq.sv
module midi_ts_seq
    import midi_ts_pkg::*;
#(
    parameter int TS_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_start,
    input  logic            cmd_stop,
    input  logic            rx_valid,
    input  byte_t           rx_data,
    input  logic [TS_W-1:0] ts_value,
    output logic            active,
    output wr_req_t         wr_req
);
    localparam int TS_BYTES = TS_W / BYTE_W;
    localparam int IDX_W    = (TS_BYTES > 1) ? $clog2(TS_BYTES) : 1;

    seq_st_e          st_q;
    logic [TS_W-1:0]  snap_q;
    byte_t            pend_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            snap_q <= '0;
            pend_q <= '0;
            idx_q  <= '0;
        end else if (cmd_start) begin
            st_q  <= ST_WAIT;
            idx_q <= '0;
        end else if (cmd_stop) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_WAIT: if (rx_valid) begin
                    snap_q <= ts_value;
                    pend_q <= rx_data;
                    idx_q  <= '0;
                    st_q   <= ST_STAMP;
                end
                ST_STAMP: begin
                    if (idx_q == IDX_W'(TS_BYTES - 1)) st_q <= ST_DATA;
                    else                               idx_q <= idx_q + 1'b1;
                end
                ST_DATA: st_q <= ST_RUN;
                default: ;
            endcase
        end
    end

    always_comb begin
        wr_req = '0;
        if (!cmd_start && !cmd_stop) begin
            case (st_q)
                ST_STAMP: begin
                    wr_req.valid = 1'b1;
                    wr_req.data  = byte_of(64'(snap_q), 3'(idx_q));
                end
                ST_DATA: begin
                    wr_req.valid = 1'b1;
                    wr_req.data  = pend_q;
                end
                ST_RUN: begin
                    wr_req.valid = rx_valid;
                    wr_req.data  = rx_data;
                end
                default: ;
            endcase
        end
    end

    assign active = (st_q != ST_IDLE);

    // R5: first stamp write carries the low byte of the captured timestamp
    p_low_first_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && rx_valid && !cmd_start && !cmd_stop) |=>
            (wr_req.valid && wr_req.data == $past(ts_value[7:0])));

    // R7: no writes while inactive
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !active |-> !wr_req.valid);
endmodule

// File: rtl/midi_ts_buf.sv
module midi_ts_buf
    import midi_ts_pkg::*;
#(
    parameter int                 TIMER_W = 16,
    parameter logic [TIMER_W-1:0] RELOAD  = 16'hFC17,
    parameter int                 TS_W    = 24,
    parameter int                 DEPTH   = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        us_tick,
    input  logic        cmd_start,
    input  logic        cmd_stop,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        host_rd,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        ts_active,
    output logic        ovf_flag
);
    logic [TS_W-1:0] ts_value;
    wr_req_t         wr_req;
    logic            full;
    logic            ovf_q;

    midi_ts_timer #(.TIMER_W(TIMER_W), .RELOAD(RELOAD), .TS_W(TS_W)) timer_i (
        .clk(clk), .rst(rst), .clr(cmd_start), .run(ts_active),
        .tick(us_tick), .ts_value(ts_value)
    );

    midi_ts_seq #(.TS_W(TS_W)) seq_i (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .rx_valid(rx_valid), .rx_data(rx_data), .ts_value(ts_value),
        .active(ts_active), .wr_req(wr_req)
    );

    midi_ts_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) fifo_i (
        .clk(clk), .rst(rst), .flush(cmd_start), .wr(wr_req.valid),
        .wr_data(wr_req.data), .rd(host_rd), .out_valid(out_valid),
        .out_data(out_data), .full(full)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd_start)          ovf_q <= 1'b0;
        else if (wr_req.valid && full) ovf_q <= 1'b1;
    end

    assign ovf_flag = ovf_q;

    // R9: overflow flag is sticky until a new command
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !cmd_start) |=> ovf_q);

    // R2: start empties the FIFO and clears the flag
    p_start_clean_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (!out_valid && !ovf_flag && ts_active));
endmodule

// File: tb/midi_ts_buf_tb_top.sv
`timescale 1ns/1ps
module midi_ts_buf_tb_top;
    localparam logic [15:0] RELOAD = 16'hFFF6;
    localparam int PERIOD = 65536 - 32'(RELOAD);
    localparam int DEPTH  = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic us_tick = 0, cmd_start = 0, cmd_stop = 0, rx_valid = 0, host_rd = 0;
    logic [7:0] rx_data = 0;
    logic out_valid, ts_active, ovf_flag;
    logic [7:0] out_data;

    int checks = 0, errors = 0;
    bit m_active = 0, m_stamped = 0, m_ovf = 0;
    int m_ticks = 0;
    logic [7:0] mq[$];

    always #10 clk = ~clk;

    midi_ts_buf #(.RELOAD(RELOAD), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .us_tick(us_tick), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .rx_valid(rx_valid), .rx_data(rx_data),
        .host_rd(host_rd), .out_valid(out_valid), .out_data(out_data),
        .ts_active(ts_active), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_ts(input int ticks);
        return 24'(ticks / PERIOD);
    endfunction

    task automatic push_m(input logic [7:0] b);
        if (mq.size() == DEPTH) m_ovf = 1;
        else mq.push_back(b);
    endtask

    task automatic cyc(input bit t);
        us_tick = t;
        if (m_active && t) m_ticks++;
        @(negedge clk);
        us_tick = 0;
    endtask

    task automatic do_start();
        cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        m_active = 1; m_stamped = 0; m_ticks = 0; m_ovf = 0;
        mq.delete();
    endtask

    task automatic do_stop();
        cmd_stop = 1;
        @(negedge clk);
        cmd_stop = 0;
        m_active = 0;
    endtask

    task automatic do_rx(input logic [7:0] b);
        logic [23:0] ts;
        rx_valid = 1; rx_data = b;
        @(negedge clk);
        rx_valid = 0;
        if (m_active) begin
            if (!m_stamped) begin
                ts = exp_ts(m_ticks);
                push_m(ts[7:0]); push_m(ts[15:8]); push_m(ts[23:16]);
                m_stamped = 1;
            end
            push_m(b);
        end
        for (int i = 0; i < 4; i++) cyc(1'($urandom % 2));
    endtask

    task automatic drain(input string req);
        while (mq.size() > 0) begin
            logic [7:0] e;
            e = mq.pop_front();
            chk(out_valid == 1'b1, req, int'(out_valid), 1);
            chk(out_data == e, req, int'(out_data), int'(e));
            host_rd = 1;
            @(negedge clk);
            host_rd = 0;
        end
        chk(out_valid == 1'b0, {req, " empty after drain"}, int'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
        chk(ts_active == 0, "R1 ts_active", int'(ts_active), 0);
        chk(ovf_flag == 0, "R1 ovf_flag", int'(ovf_flag), 0);

        // R8 read of empty FIFO ignored
        host_rd = 1; @(negedge clk); host_rd = 0;
        chk(out_valid == 0, "R8 empty read", int'(out_valid), 0);

        // R7 byte while inactive ignored
        do_rx(8'h11);
        chk(out_valid == 0, "R7 inactive byte", int'(out_valid), 0);

        // R4 R5 R6 directed: 37 ticks -> stamp 3
        do_start();
        chk(ts_active == 1, "R4 active after start", int'(ts_active), 1);
        for (int i = 0; i < 37; i++) cyc(1);
        do_rx(8'hA5);
        do_rx(8'h3C);
        drain("R5 R6 stamp then data");

        do_stop();
        chk(ts_active == 0, "R4 inactive after stop", int'(ts_active), 0);
        do_rx(8'h77);
        chk(out_valid == 0, "R7 byte after stop", int'(out_valid), 0);

        // R3 middle byte: 2605 ticks -> 260
        do_start();
        for (int i = 0; i < 2605; i++) cyc(1);
        do_rx(8'h5A);
        drain("R3 mid byte stamp");
        do_stop();

        // R3 R5 R6 random runs
        for (int it = 0; it < 8; it++) begin
            int nt, nb;
            do_start();
            nt = int'($urandom % 400);
            for (int i = 0; i < nt; i++) cyc(1'($urandom % 4 != 0));
            nb = 1 + int'($urandom % 4);
            for (int k = 0; k < nb; k++) do_rx(8'($urandom));
            drain("R3 R5 R6 random");
            do_stop();
        end

        // R2 restart clears counter
        do_start();
        for (int i = 0; i < 25; i++) cyc(1);
        do_rx(8'h01);
        do_start();
        chk(out_valid == 0, "R2 restart flushes", int'(out_valid), 0);
        for (int i = 0; i < 5; i++) cyc(1);
        do_rx(8'hC3);
        drain("R2 restart stamp");

        // R9 overflow: 3 stamp + 6 data into depth 8
        do_start();
        for (int i = 0; i < 12; i++) cyc(1);
        for (int k = 0; k < 6; k++) do_rx(8'h40 + 8'(k));
        chk(ovf_flag == m_ovf, "R9 overflow flag", int'(ovf_flag), int'(m_ovf));
        drain("R9 kept bytes");
        chk(ovf_flag == 1, "R9 flag sticky", int'(ovf_flag), 1);
        do_start();
        chk(ovf_flag == 0, "R2 start clears ovf", int'(ovf_flag), 0);
        do_stop();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule